// File: doc/BRIEF.md
# Coprocessor-Condition Branch Unit

This block resolves branches whose condition is the busy state of an attached coprocessor rather than a comparison of general registers. When the decode stage presents such an instruction word, together with its address and a strobe, the unit samples the coprocessor busy flag in that same cycle. One clock later it presents four results: whether the branch is taken, the 32-bit branch target, whether the delay-slot instruction must be cancelled, and whether the encoding is illegal.

Two sense variants exist. The "on idle" variants branch when the coprocessor is free, and the "on busy" variants branch when it is occupied. Each sense has a plain form and a likely form. A likely branch that is not taken cancels its delay-slot instruction. A plain branch always lets the delay slot run. A taken branch takes effect after the delay slot. The surrounding pipeline performs the redirect and the cancellation; this unit only supplies the decisions and the address.

Top module: `cbr_branch_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released with no strobe, every output is 0: `res_valid_o`, `taken_o`, `nullify_o`, `illegal_o`, and `target_o` = 32'h0.
- R2: `res_valid_o` is high in exactly the cycle after a cycle in which `dec_valid_i` was high, and low otherwise.
- R3: For every strobe, `target_o` = `pc_i` + 4 + (sign-extended `instr_i[15:0]` × 4), computed modulo 2^32.
- R4: For a legal encoding, the selector in `instr_i[20:16]` sets the branch sense through its bit 16. Selectors 0 and 2 (bit 16 = 0) are taken when `cop_busy_i` is 0. Selectors 1 and 3 (bit 16 = 1) are taken when `cop_busy_i` is 1.
- R5: Selectors 2 and 3 (bit 17 = 1) are the likely forms, and they raise `nullify_o` exactly when the branch is not taken. Selectors 0 and 1 never raise `nullify_o`. `taken_o` and `nullify_o` are never high together.
- R6: An encoding is legal only when `instr_i[25:21]` = 5'h08 and `instr_i[20:16]` ≤ 3. For any other encoding, `illegal_o` is 1 and `taken_o` and `nullify_o` are 0.
- R7: Only the value of `cop_busy_i` in the strobe cycle counts. A later change of `cop_busy_i` does not alter the results. In a cycle without a strobe, `taken_o`, `nullify_o` and `illegal_o` are 0, and `target_o` keeps its last value.
- R8: `instr_i[31:26]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decode strobe: an instruction for this unit is present |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the branch instruction |
| cop_busy_i | input | 1 | Coprocessor busy condition, sampled with the strobe |
| res_valid_o | output | 1 | Results below belong to the previous strobe |
| taken_o | output | 1 | Branch taken (takes effect after the delay slot) |
| nullify_o | output | 1 | Cancel the delay-slot instruction |
| illegal_o | output | 1 | Encoding is not a legal condition branch |
| target_o | output | 32 | Branch target address |

## Verification
The embedded properties watch, on every cycle, the one-cycle relation between the strobe and `res_valid_o`, the exclusivity of taken and nullify, the silence of an illegal result, the target holding between strobes, and the taken or not-taken outcome of the plain selectors for a given busy value. The bench's vector table is what shows that the target arithmetic wraps correctly at both ends of the address space, that every selector and busy pairing yields the right taken and nullify pair, and that an unrelated major field or an out-of-range selector is flagged. Insensitivity to a busy change after the strobe and to the top opcode bits also needs its own directed scenarios.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Selector codes carried in the minor field of the instruction
  typedef enum logic [1:0] {
    SEL_ON_IDLE        = 2'd0,
    SEL_ON_BUSY        = 2'd1,
    SEL_ON_IDLE_LIKELY = 2'd2,
    SEL_ON_BUSY_LIKELY = 2'd3
  } cbr_sel_e;

  // Decoded properties of one instruction
  typedef struct packed {
    logic legal;    // encoding belongs to this unit
    logic likely;   // cancels delay slot when not taken
    logic on_busy;  // branch sense: taken when busy
  } cbr_dec_t;

  // Decision produced for one instruction
  typedef struct packed {
    logic taken;
    logic nullify;
    logic illegal;
  } cbr_res_t;

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter logic [FIELD_W-1:0] MAJOR_CODE = 5'h08
) (
  input  logic [FIELD_W-1:0] major_i,
  input  logic [FIELD_W-1:0] minor_i,
  output cbr_dec_t           dec_o
);
  localparam int SEL_W = 2;

  logic major_hit;
  logic minor_in_range;
  cbr_sel_e sel;

  assign major_hit      = (major_i == MAJOR_CODE);
  assign minor_in_range = (minor_i[FIELD_W-1:SEL_W] == '0);
  assign sel            = cbr_sel_e'(minor_i[SEL_W-1:0]);

  always_comb begin
    dec_o.legal = major_hit && minor_in_range;
    unique case (sel)
      SEL_ON_IDLE:        begin dec_o.likely = 1'b0; dec_o.on_busy = 1'b0; end
      SEL_ON_BUSY:        begin dec_o.likely = 1'b0; dec_o.on_busy = 1'b1; end
      SEL_ON_IDLE_LIKELY: begin dec_o.likely = 1'b1; dec_o.on_busy = 1'b0; end
      SEL_ON_BUSY_LIKELY: begin dec_o.likely = 1'b1; dec_o.on_busy = 1'b1; end
      default:            begin dec_o.likely = 1'b0; dec_o.on_busy = 1'b0; end
    endcase
  end

endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
  import cbr_pkg::*;
(
  input  cbr_dec_t dec_i,
  input  logic     busy_i,
  output cbr_res_t res_o
);
  logic cond_met;

  assign cond_met = (busy_i == dec_i.on_busy);

  always_comb begin
    res_o.illegal = !dec_i.legal;
    res_o.taken   = dec_i.legal && cond_met;
    res_o.nullify = dec_i.legal && dec_i.likely && !cond_met;
  end

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 2,
  parameter int SLOT_B  = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

  function automatic logic [ADDR_W-1:0] byte_offset(input logic [OFF_W-1:0] off);
    return {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] branch_dest(input logic [ADDR_W-1:0] pc,
                                                    input logic [OFF_W-1:0]  off);
    return pc + ADDR_W'(SLOT_B) + byte_offset(off);
  endfunction

  assign target_o = branch_dest(pc_i, off_i);

endmodule

// File: rtl/cbr_branch_unit.sv
module cbr_branch_unit
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int OFF_W  = 16,
  parameter int FIELD_W = 5,
  parameter logic [FIELD_W-1:0] MAJOR_CODE = 5'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_i,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              cop_busy_i,
  output logic              res_valid_o,
  output logic              taken_o,
  output logic              nullify_o,
  output logic              illegal_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int MINOR_LO = OFF_W;
  localparam int MAJOR_LO = OFF_W + FIELD_W;
  localparam int USED_W   = MAJOR_LO + FIELD_W;

  // Named internal events
  cbr_dec_t          dec_w;
  cbr_res_t          nxt_res;
  logic [ADDR_W-1:0] nxt_target;
  logic              unused_opc;

  assign unused_opc = ^instr_i[INSN_W-1:USED_W];

  cbr_decode #(.FIELD_W(FIELD_W), .MAJOR_CODE(MAJOR_CODE)) u_decode (
    .major_i (instr_i[MAJOR_LO +: FIELD_W]),
    .minor_i (instr_i[MINOR_LO +: FIELD_W]),
    .dec_o   (dec_w)
  );

  cbr_resolve u_resolve (
    .dec_i  (dec_w),
    .busy_i (cop_busy_i),
    .res_o  (nxt_res)
  );

  cbr_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(2), .SLOT_B(4)) u_target (
    .pc_i     (pc_i),
    .off_i    (instr_i[OFF_W-1:0]),
    .target_o (nxt_target)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      nullify_o   <= 1'b0;
      illegal_o   <= 1'b0;
      target_o    <= '0;
    end else begin
      res_valid_o <= dec_valid_i;
      taken_o     <= dec_valid_i && nxt_res.taken;
      nullify_o   <= dec_valid_i && nxt_res.nullify;
      illegal_o   <= dec_valid_i && nxt_res.illegal;
      if (dec_valid_i) target_o <= nxt_target;
    end
  end

  // ---------------- assertions ----------------
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> res_valid_o);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !res_valid_o);

  a_r4_idle_form: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && instr_i[MAJOR_LO +: FIELD_W] == MAJOR_CODE
      && instr_i[MINOR_LO +: FIELD_W] == FIELD_W'(0)
    |=> taken_o == !$past(cop_busy_i));

  a_r4_busy_form: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && instr_i[MAJOR_LO +: FIELD_W] == MAJOR_CODE
      && instr_i[MINOR_LO +: FIELD_W] == FIELD_W'(1)
    |=> taken_o == $past(cop_busy_i));

  a_r5_plain_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && !instr_i[MINOR_LO+1] |=> !nullify_o);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && nullify_o));

  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !taken_o && !nullify_o && res_valid_o);

  a_r7_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> $stable(target_o));

  a_r7_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> !taken_o && !nullify_o && !illegal_o);

endmodule

// File: tb/test_cbr_branch_unit.sv
module test_cbr_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam int VW = 32 + 32 + 1 + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic        cop_busy_i = 1'b0;
  logic        res_valid_o, taken_o, nullify_o, illegal_o;
  logic [31:0] target_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_branch_unit i_cbr_branch_unit (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .cop_busy_i(cop_busy_i), .res_valid_o(res_valid_o),
    .taken_o(taken_o), .nullify_o(nullify_o), .illegal_o(illegal_o),
    .target_o(target_o)
  );

  function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] maj,
                                      input logic [4:0] sel, input logic [15:0] off);
    return {opc, maj, sel, off};
  endfunction

  // Independent restatement: signed multiply instead of bit concatenation
  function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [15:0] off);
    int signed soff;
    soff = int'($signed(off));
    return pc + 32'd4 + 32'(soff * 4);
  endfunction

  // {instr, pc, busy, exp_taken, exp_nullify, exp_illegal}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h4900_0004, 32'h0000_1000, 1'b0, 3'b100},  // sel0 idle  -> taken
    {32'h4900_0004, 32'h0000_1000, 1'b1, 3'b000},  // sel0 busy  -> not taken
    {32'h4901_0010, 32'h0000_2000, 1'b1, 3'b100},  // sel1 busy  -> taken
    {32'h4901_0010, 32'h0000_2000, 1'b0, 3'b000},  // sel1 idle
    {32'h4902_0020, 32'h0000_3000, 1'b0, 3'b100},  // sel2 idle  -> taken
    {32'h4902_0020, 32'h0000_3000, 1'b1, 3'b010},  // sel2 busy  -> nullify
    {32'h4903_0001, 32'h0000_4000, 1'b1, 3'b100},  // sel3 busy  -> taken
    {32'h4903_0001, 32'h0000_4000, 1'b0, 3'b010},  // sel3 idle  -> nullify
    {32'h4900_FFFF, 32'h0000_0000, 1'b0, 3'b100},  // -1 word from 0
    {32'h4901_8000, 32'h0000_0010, 1'b1, 3'b100},  // most negative, wraps low
    {32'h4900_7FFF, 32'hFFFF_FFFC, 1'b0, 3'b100},  // most positive, wraps high
    {32'h4904_0000, 32'h0000_5000, 1'b1, 3'b001},  // selector 4 illegal
    {32'h4920_0000, 32'h0000_6000, 1'b0, 3'b001},  // major 9 illegal
    {32'h491F_0000, 32'h0000_7000, 1'b1, 3'b001}   // selector 31 illegal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Drive one strobe at a falling edge; results are checked one cycle later
  task automatic issue(input logic [31:0] ins, input logic [31:0] pc, input logic busy);
    @(negedge clk);
    dec_valid_i = 1'b1;
    instr_i = ins;
    pc_i = pc;
    cop_busy_i = busy;
    @(negedge clk);
    dec_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(res_valid_o), 0);
    chk("R1 flags", {29'd0, taken_o, nullify_o, illegal_o}, 0);
    chk("R1 target", target_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {28'd0, res_valid_o, taken_o, nullify_o, illegal_o}, 0);
    chk("R1 target after release", target_o, 0);

    // Vector table: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic [31:0] ins, pc;
      logic b;
      logic [2:0] e;
      {ins, pc, b, e} = VEC[k];
      issue(ins, pc, b);
      chk("R2 valid after strobe", 32'(res_valid_o), 1);
      chk("R4/R5/R6 taken,nullify,illegal", {29'd0, taken_o, nullify_o, illegal_o}, {29'd0, e});
      chk("R3 target", target_o, exp_target(pc, ins[15:0]));
      if (taken_o && nullify_o) chk("R5 exclusive", 1, 0);
    end

    // R2 / R7: idle cycle clears flags, holds target
    begin
      logic [31:0] held;
      held = target_o;
      @(negedge clk);
      chk("R2 valid idle", 32'(res_valid_o), 0);
      chk("R7 flags idle", {29'd0, taken_o, nullify_o, illegal_o}, 0);
      chk("R7 target held", target_o, held);
    end

    // R7: busy flips after the strobe, result uses strobe-cycle value
    @(negedge clk);
    dec_valid_i = 1'b1; instr_i = 32'h4903_0008; pc_i = 32'h0000_8000; cop_busy_i = 1'b0;
    @(negedge clk);
    dec_valid_i = 1'b0; cop_busy_i = 1'b1;
    chk("R7 sampled busy (nullify)", {30'd0, taken_o, nullify_o}, 32'h1);
    @(negedge clk);
    chk("R7 late busy ignored", {29'd0, taken_o, nullify_o, illegal_o}, 0);
    chk("R7 target kept", target_o, exp_target(32'h0000_8000, 16'h0008));

    // R8: top opcode bits have no effect
    issue(enc(6'h00, 5'h08, 5'd1, 16'h0040), 32'h0000_9000, 1'b1);
    chk("R8 opcode ignored flags", {29'd0, taken_o, nullify_o, illegal_o}, 32'h4);
    chk("R8 opcode ignored target", target_o, 32'h0000_9104);
    issue(enc(6'h3F, 5'h08, 5'd2, 16'h0040), 32'h0000_9000, 1'b1);
    chk("R8 opcode ignored likely", {29'd0, taken_o, nullify_o, illegal_o}, 32'h2);

    // R2: back-to-back strobes
    @(negedge clk);
    dec_valid_i = 1'b1; instr_i = enc(6'h12, 5'h08, 5'd0, 16'h0001); pc_i = 32'h100; cop_busy_i = 1'b0;
    @(negedge clk);
    chk("R2 first of pair", {29'd0, taken_o, res_valid_o, illegal_o}, 32'h6);
    instr_i = enc(6'h12, 5'h08, 5'd0, 16'h0002); pc_i = 32'h200; cop_busy_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    chk("R2 second of pair", {29'd0, taken_o, res_valid_o, illegal_o}, 32'h2);
    chk("R3 second target", target_o, 32'h20C);

    // R1: reset mid-stream clears everything
    issue(enc(6'h12, 5'h08, 5'd0, 16'h0001), 32'h300, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", {28'd0, res_valid_o, taken_o, nullify_o, illegal_o}, 0);
    chk("R1 reset target", target_o, 0);

    report();
  end

endmodule